// File: doc/BRIEF.md
# Four-Level Translation Table Walker

This block turns a 64-bit virtual address into a physical address. It reads a four-level translation table from memory, one 8-byte descriptor per level. The lower 48 bits of the address index the tables: four 9-bit fields, one per level, followed by a 12-bit page offset. The upper 16 bits must be a sign-style copy: all zero selects the low-region root pointer and all one selects the high-region root pointer. Any other pattern fails at once and touches no memory.

At each level the walker sends one read of an 8-byte-aligned address to a simple memory port and waits for the descriptor. The descriptor either points to the next table, ends the walk with a mapping (a 1 GB block at level 2, or a 4 KB page at level 4), or ends it with a fault. The response carries the physical address on success, or a fault code and the level at which the walk stopped. Only one walk is in flight at a time. The requester sees this as a ready signal that is high only while the walker is idle.

Top module: `xlat_walk`

## Requirements
- R1: If bits [63:48] of an accepted address are neither all zero nor all one, the walker issues no memory read. It presents rsp_valid in the cycle after acceptance, with rsp_level 0 and rsp_fault 1 for an instruction fetch (req_is_fetch=1) or 2 for a data access.
- R2: When bits [63:48] are all zero, the first read goes to root0_base with its low 12 bits cleared, plus 8 times va[47:39]. When those bits are all one, root1_base is used the same way.
- R3: The read at level L (1..4) goes to the current table base plus 8 times the level's index field. The index fields are va[47:39], va[38:30], va[29:21] and va[20:12] for levels 1 to 4. Exactly one read is made per level visited.
- R4: A descriptor with bits [1:0]=2'b11 at levels 1 to 3 is a table pointer. The next table base is descriptor bits [47:12] followed by 12 zero bits.
- R5: A descriptor with bits [1:0]=2'b01 at level 2 and bit 10 set is a 1 GB block. The response has rsp_fault 0, rsp_level 2, and rsp_paddr = {desc[47:30], va[29:0]}.
- R6: A descriptor with bits [1:0]=2'b11 at level 4 and bit 10 set is a 4 KB page. The response has rsp_fault 0, rsp_level 4, and rsp_paddr = {desc[47:12], va[11:0]}.
- R7: A descriptor with bit 0 clear, including an all-zero descriptor, ends the walk with rsp_fault 3 and rsp_level equal to the level that was read.
- R8: A descriptor with bits [1:0]=2'b01 at level 1, 3 or 4 ends the walk with rsp_fault 3 and rsp_level equal to that level.
- R9: A block or page descriptor with bit 10 clear ends the walk with rsp_fault 4 and rsp_level equal to that level.
- R10: req_ready is high only while no walk is in progress. A request offered while the walker is busy, including in the response cycle, is ignored: it causes no read and no response. Each accepted request gives exactly one response, with rsp_valid high for one cycle. On a fault, rsp_paddr is 0.
- R11: During and right after reset, req_ready is 1, mem_req_valid is 0 and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle; the request is taken in this cycle |
| req_vaddr | input | 64 | Virtual address to translate |
| req_is_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| root0_base | input | 48 | Level-1 table address for the low region |
| root1_base | input | 48 | Level-1 table address for the high region |
| mem_req_valid | output | 1 | One-cycle descriptor read request |
| mem_req_addr | output | 48 | Byte address of the descriptor |
| mem_resp_valid | input | 1 | Descriptor data returned |
| mem_resp_data | input | 64 | Descriptor value |
| rsp_valid | output | 1 | Walk result present (one cycle) |
| rsp_paddr | output | 48 | Translated physical address, 0 on a fault |
| rsp_fault | output | 3 | 0 none, 1 fetch range, 2 data range, 3 translation, 4 access flag |
| rsp_level | output | 3 | Level that ended the walk, 0 for a range fault |

## Verification
Two events can fall in the same cycle: the walker presenting its response, and a new request arriving. In that cycle the walker must refuse the newcomer, because it leaves the busy state only on the following edge. The bench provokes this with range-fault walks, whose response comes one cycle after acceptance, and by holding a second, well-mapped request in exactly that cycle. It judges the result at the ports: req_ready must be low in that cycle, and afterwards no extra memory read and no second response may appear. The same intruding request is also offered during the read phase of ordinary walks, with memory latency varied from one to three cycles.

// File: rtl/xlat_walk_pkg.sv
package xlat_walk_pkg;

   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_IRANGE = 3'd1,
      FLT_DRANGE = 3'd2,
      FLT_XLATE  = 3'd3,
      FLT_ACCESS = 3'd4
   } fault_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_DONE
   } walk_st_e;

endpackage

// File: rtl/xlat_region_chk.sv
module xlat_region_chk #(
   parameter int VADDR_W  = 64,
   parameter int REGION_W = 48
) (
   input  logic [VADDR_W-1:0] va,
   output logic               in_low,
   output logic               in_high,
   output logic               out_of_range
);
   localparam int TOP_W = VADDR_W - REGION_W;

   logic [TOP_W-1:0] top_bits;
   logic [REGION_W-1:0] unused_region;

   assign top_bits      = va[VADDR_W-1:REGION_W];
   assign unused_region = va[REGION_W-1:0];
   assign in_low        = ~|top_bits;
   assign in_high       = &top_bits;
   assign out_of_range  = ~(in_low | in_high);
endmodule

// File: rtl/xlat_index_sel.sv
module xlat_index_sel #(
   parameter int LEVELS = 4,
   parameter int IDX_W  = 9,
   parameter int LVL_W  = 3
) (
   input  logic [IDX_W*LEVELS-1:0] va_idx,
   input  logic [LVL_W-1:0]        lvl,
   output logic [IDX_W-1:0]        idx
);
   logic [IDX_W-1:0] per_lvl [LEVELS];

   for (genvar g = 0; g < LEVELS; g++) begin : g_field
      assign per_lvl[g] = va_idx[(LEVELS-1-g)*IDX_W +: IDX_W];
   end

   always_comb begin
      idx = '0;
      for (int k = 0; k < LEVELS; k++) begin
         if (lvl == LVL_W'(k + 1)) idx = per_lvl[k];
      end
   end
endmodule

// File: rtl/xlat_desc_dec.sv
module xlat_desc_dec
   import xlat_walk_pkg::*;
#(
   parameter int LEVELS      = 4,
   parameter int BLOCK_LEVEL = 2,
   parameter int LVL_W       = 3
) (
   input  logic [1:0]       typ,
   input  logic             af,
   input  logic [LVL_W-1:0] lvl,
   output logic             take_table,
   output logic             take_leaf,
   output fault_e           fault
);
   logic last_lvl;
   logic blk_here;
   logic leaf_cand;

   assign last_lvl = (lvl == LVL_W'(LEVELS));

   if (BLOCK_LEVEL == 0) begin : g_no_block
      assign blk_here = 1'b0;
   end else begin : g_block
      assign blk_here = (lvl == LVL_W'(BLOCK_LEVEL));
   end

   assign leaf_cand  = ((typ == 2'b11) && last_lvl) || ((typ == 2'b01) && blk_here);
   assign take_table = (typ == 2'b11) && !last_lvl;
   assign take_leaf  = leaf_cand && af;

   always_comb begin
      if (!typ[0])         fault = FLT_XLATE;
      else if (take_table) fault = FLT_NONE;
      else if (leaf_cand)  fault = af ? FLT_NONE : FLT_ACCESS;
      else                 fault = FLT_XLATE;
   end
endmodule

// File: rtl/xlat_leaf_form.sv
module xlat_leaf_form #(
   parameter int LEVELS = 4,
   parameter int IDX_W  = 9,
   parameter int PG_W   = 12,
   parameter int PA_W   = 48,
   parameter int LVL_W  = 3
) (
   input  logic [PA_W-1:0]  desc_pa,
   input  logic [PA_W-1:0]  va_pa,
   input  logic [LVL_W-1:0] lvl,
   output logic [PA_W-1:0]  pa
);
   logic [PA_W-1:0] cand [LEVELS];

   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      localparam int OFF = PG_W + IDX_W * (LEVELS - 1 - g);
      localparam logic [PA_W-1:0] KEEP = {PA_W{1'b1}} << OFF;
      assign cand[g] = (desc_pa & KEEP) | (va_pa & ~KEEP);
   end

   always_comb begin
      pa = '0;
      for (int k = 0; k < LEVELS; k++) begin
         if (lvl == LVL_W'(k + 1)) pa = cand[k];
      end
   end
endmodule

// File: rtl/xlat_walk.sv
module xlat_walk
   import xlat_walk_pkg::*;
#(
   parameter int VADDR_W     = 64,
   parameter int PA_W        = 48,
   parameter int DESC_W      = 64,
   parameter int LEVELS      = 4,
   parameter int IDX_W       = 9,
   parameter int PG_W        = 12,
   parameter int BLOCK_LEVEL = 2,
   parameter int AF_BIT      = 10,
   localparam int LVL_W      = $clog2(LEVELS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VADDR_W-1:0] req_vaddr,
   input  logic               req_is_fetch,
   input  logic [PA_W-1:0]    root0_base,
   input  logic [PA_W-1:0]    root1_base,
   output logic               mem_req_valid,
   output logic [PA_W-1:0]    mem_req_addr,
   input  logic               mem_resp_valid,
   input  logic [DESC_W-1:0]  mem_resp_data,
   output logic               rsp_valid,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic [2:0]         rsp_fault,
   output logic [LVL_W-1:0]   rsp_level
);
   localparam int REGION_W = PG_W + IDX_W * LEVELS;
   localparam int IDXV_W   = IDX_W * LEVELS;

   if (REGION_W >= VADDR_W) begin : g_bad_region
      $error("translated region must leave upper bits for the region check");
   end
   if (PA_W > REGION_W || PA_W <= PG_W + IDX_W * (LEVELS - 1)) begin : g_bad_pa
      $error("physical width out of range for this table layout");
   end
   if (DESC_W != 64 || PA_W >= DESC_W) begin : g_bad_desc
      $error("descriptors must be 8 bytes and wider than the physical address");
   end
   if (IDX_W + 3 > PG_W) begin : g_bad_idx
      $error("a table of descriptors must fit in one page");
   end
   if (BLOCK_LEVEL < 0 || BLOCK_LEVEL >= LEVELS) begin : g_bad_blk
      $error("block level must lie below the last level");
   end
   if (AF_BIT < 2 || AF_BIT >= PG_W) begin : g_bad_af
      $error("access flag must sit in the descriptor attribute bits");
   end

   walk_st_e            st;
   logic [REGION_W-1:0] va_q;
   logic [LVL_W-1:0]    lvl_q;
   logic [PA_W-1:0]     base_q;
   logic [PA_W-1:0]     rsp_pa_q;
   fault_e              rsp_flt_q;
   logic [LVL_W-1:0]    rsp_lvl_q;

   logic                rng_lo, rng_hi, rng_bad;
   logic [IDX_W-1:0]    cur_idx;
   logic                dec_table, dec_leaf;
   fault_e              dec_fault;
   logic [PA_W-1:0]     leaf_pa;
   logic [PA_W-1:0]     root0_aln, root1_aln;
   logic                unused_bits;

   assign unused_bits = ^{root0_base[PG_W-1:0], root1_base[PG_W-1:0],
                          mem_resp_data[DESC_W-1:PA_W]};
   assign root0_aln   = {root0_base[PA_W-1:PG_W], {PG_W{1'b0}}};
   assign root1_aln   = {root1_base[PA_W-1:PG_W], {PG_W{1'b0}}};

   xlat_region_chk #(
      .VADDR_W (VADDR_W),
      .REGION_W(REGION_W)
   ) u_region (
      .va          (req_vaddr),
      .in_low      (rng_lo),
      .in_high     (rng_hi),
      .out_of_range(rng_bad)
   );

   xlat_index_sel #(
      .LEVELS(LEVELS),
      .IDX_W (IDX_W),
      .LVL_W (LVL_W)
   ) u_index (
      .va_idx(va_q[REGION_W-1:PG_W]),
      .lvl   (lvl_q),
      .idx   (cur_idx)
   );

   xlat_desc_dec #(
      .LEVELS     (LEVELS),
      .BLOCK_LEVEL(BLOCK_LEVEL),
      .LVL_W      (LVL_W)
   ) u_decode (
      .typ       (mem_resp_data[1:0]),
      .af        (mem_resp_data[AF_BIT]),
      .lvl       (lvl_q),
      .take_table(dec_table),
      .take_leaf (dec_leaf),
      .fault     (dec_fault)
   );

   xlat_leaf_form #(
      .LEVELS(LEVELS),
      .IDX_W (IDX_W),
      .PG_W  (PG_W),
      .PA_W  (PA_W),
      .LVL_W (LVL_W)
   ) u_leaf (
      .desc_pa(mem_resp_data[PA_W-1:0]),
      .va_pa  (va_q[PA_W-1:0]),
      .lvl    (lvl_q),
      .pa     (leaf_pa)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         va_q      <= '0;
         lvl_q     <= '0;
         base_q    <= '0;
         rsp_pa_q  <= '0;
         rsp_flt_q <= FLT_NONE;
         rsp_lvl_q <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q <= req_vaddr[REGION_W-1:0];
                  if (rng_bad) begin
                     rsp_flt_q <= req_is_fetch ? FLT_IRANGE : FLT_DRANGE;
                     rsp_lvl_q <= '0;
                     rsp_pa_q  <= '0;
                     st        <= ST_DONE;
                  end else begin
                     base_q <= rng_hi ? root1_aln : root0_aln;
                     lvl_q  <= LVL_W'(1);
                     st     <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: st <= ST_WAIT;
            ST_WAIT: begin
               if (mem_resp_valid) begin
                  if (dec_table) begin
                     base_q <= {mem_resp_data[PA_W-1:PG_W], {PG_W{1'b0}}};
                     lvl_q  <= lvl_q + LVL_W'(1);
                     st     <= ST_ISSUE;
                  end else begin
                     rsp_flt_q <= dec_fault;
                     rsp_lvl_q <= lvl_q;
                     rsp_pa_q  <= dec_leaf ? leaf_pa : '0;
                     st        <= ST_DONE;
                  end
               end
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (st == ST_IDLE);
   assign mem_req_valid = (st == ST_ISSUE);
   assign mem_req_addr  = base_q | {{(PA_W-IDX_W-3){1'b0}}, cur_idx, 3'b000};
   assign rsp_valid     = (st == ST_DONE);
   assign rsp_paddr     = rsp_pa_q;
   assign rsp_fault     = rsp_flt_q;
   assign rsp_level     = rsp_lvl_q;

   // R1: an out-of-range address answers next cycle without touching memory
   assert_range_no_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid && rng_bad) |=>
         (rsp_valid && !mem_req_valid && rsp_level == '0 &&
          rsp_fault == ($past(req_is_fetch) ? 3'(FLT_IRANGE) : 3'(FLT_DRANGE))));

   // R2: first read lies in the root table chosen by the top address bits
   assert_root_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid && !rng_bad) |=>
         (mem_req_valid && mem_req_addr[PA_W-1:PG_W] ==
          ($past(rng_hi) ? $past(root1_base[PA_W-1:PG_W]) : $past(root0_base[PA_W-1:PG_W]))));

   // R3: descriptor reads are 8-byte aligned
   assert_read_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

   // R4: a table descriptor steers the next read into the table it names
   assert_table_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && mem_resp_valid && dec_table) |=>
         (mem_req_valid && mem_req_addr[PA_W-1:PG_W] == $past(mem_resp_data[PA_W-1:PG_W])));

   // R6: a successful walk keeps the page offset of the virtual address
   assert_offset_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 3'(FLT_NONE)) |-> (rsp_paddr[PG_W-1:0] == va_q[PG_W-1:0]));

   // R7: a translation fault always names a real table level
   assert_fault_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 3'(FLT_XLATE)) |->
         (rsp_level != '0 && rsp_level <= LVL_W'(LEVELS)));

   // R10: at most one read in flight, single-cycle response, busy while answering
   assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);
   assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   assert_busy_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid || mem_req_valid) |-> !req_ready);
endmodule

// File: tb/xlat_walk_bench.sv
module xlat_walk_bench;
   localparam logic [63:0] T1 = 64'h1000_0000;
   localparam logic [63:0] T2 = 64'h1000_1000;
   localparam logic [63:0] T3 = 64'h1000_2000;
   localparam logic [63:0] T4 = 64'h1000_3000;
   localparam logic [63:0] U1 = 64'h3000_0000;
   localparam logic [63:0] AF = 64'h400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_vaddr = '0;
   logic        req_is_fetch = 1'b0;
   logic [47:0] root0_base = T1[47:0];
   logic [47:0] root1_base = U1[47:0];
   logic        mem_req_valid;
   logic [47:0] mem_req_addr;
   logic        mem_resp_valid;
   logic [63:0] mem_resp_data;
   logic        rsp_valid;
   logic [47:0] rsp_paddr;
   logic [2:0]  rsp_fault;
   logic [2:0]  rsp_level;

   int vectors = 0;
   int miscompares = 0;
   int lat = 1;
   int rd_cnt = 0;
   logic [47:0] rd_log [8];

   logic [47:0] exp_pa;
   logic [2:0]  exp_flt;
   int          exp_lvl;
   int          exp_n;
   logic [47:0] exp_ad [4];

   always #4 clk = ~clk;

   xlat_walk u_xlat_walk (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_vaddr     (req_vaddr),
      .req_is_fetch  (req_is_fetch),
      .root0_base    (root0_base),
      .root1_base    (root1_base),
      .mem_req_valid (mem_req_valid),
      .mem_req_addr  (mem_req_addr),
      .mem_resp_valid(mem_resp_valid),
      .mem_resp_data (mem_resp_data),
      .rsp_valid     (rsp_valid),
      .rsp_paddr     (rsp_paddr),
      .rsp_fault     (rsp_fault),
      .rsp_level     (rsp_level)
   );

   function automatic logic [63:0] mem_fn(input logic [63:0] a);
      logic [63:0] pg;
      int i;
      pg = a & ~64'hFFF;
      i  = int'((a & 64'hFFF) >> 3);
      if (pg == T1) begin
         if (i == 0 || i == 511) return T2 | 64'h3;
         if (i == 2)             return 64'h4000_0000 | AF | 64'h1;
         return 64'h0;
      end
      if (pg == U1) begin
         if (i == 0 || i == 511) return T2 | 64'h3;
         if (i == 3)             return T3 | AF | 64'h1;
         return 64'h0;
      end
      if (pg == T2) begin
         case (i)
            0: return 64'h0000_0000 | AF | 64'h1;
            1: return T3 | 64'h3;
            2: return 64'h8000_0000 | AF | 64'h1;
            3: return 64'hC000_0000 | 64'h1;
            4: return T3 | AF | 64'h3;
            5: return 64'h0000_0010;
            default: return 64'h0;
         endcase
      end
      if (pg == T3) begin
         if (i == 0) return T4 | 64'h3;
         if (i == 1) return 64'h5000_0000 | AF | 64'h1;
         return 64'h0;
      end
      if (pg == T4) begin
         case (i)
            3: return 64'h0;
            5: return 64'h2000_5000 | 64'h3;
            6: return 64'h2000_6000 | AF | 64'h1;
            7: return 64'hFFFF_8000_2000_7000 | AF | 64'h3;
            default: if (i < 8) return (64'h2000_0000 + (64'(i) << 12)) | AF | 64'h3;
                     else return 64'h0;
         endcase
      end
      return 64'h0;
   endfunction

   initial begin
      logic [47:0] pend;
      int cd;
      pend = '0;
      cd = 0;
      mem_resp_valid = 1'b0;
      mem_resp_data  = '0;
      forever begin
         @(negedge clk);
         mem_resp_valid = 1'b0;
         if (cd > 0) begin
            cd--;
            if (cd == 0) begin
               mem_resp_valid = 1'b1;
               mem_resp_data  = mem_fn({16'h0, pend});
            end
         end
         if (rst_n && mem_req_valid) begin
            pend = mem_req_addr;
            rd_log[rd_cnt % 8] = mem_req_addr;
            rd_cnt++;
            cd = lat;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic ref_walk(input logic [63:0] va, input logic fetch);
      logic [15:0] top;
      logic [63:0] base, a, d;
      bit done;
      top = va[63:48];
      exp_n = 0;
      exp_pa = '0;
      exp_lvl = 0;
      if (top != 16'h0000 && top != 16'hFFFF) begin
         exp_flt = fetch ? 3'd1 : 3'd2;
         return;
      end
      base = (top == 16'h0000) ? T1 : U1;
      done = 1'b0;
      for (int lv = 1; lv <= 4 && !done; lv++) begin
         a = base + (((va >> (12 + 9 * (4 - lv))) & 64'h1FF) << 3);
         exp_ad[exp_n] = a[47:0];
         exp_n++;
         d = mem_fn(a);
         exp_lvl = lv;
         done = 1'b1;
         if (!d[0]) exp_flt = 3'd3;
         else if (d[1:0] == 2'b11 && lv < 4) begin
            base = {16'h0, d[47:12], 12'h0};
            done = 1'b0;
         end else if ((d[1:0] == 2'b11 && lv == 4) || (d[1:0] == 2'b01 && lv == 2)) begin
            if (!d[10]) exp_flt = 3'd4;
            else begin
               exp_flt = 3'd0;
               exp_pa = (lv == 2) ? {d[47:30], va[29:0]} : {d[47:12], va[11:0]};
            end
         end else exp_flt = 3'd3;
      end
   endtask

   function automatic string tag_for(input logic [2:0] f, input int lv);
      if (f == 3'd1 || f == 3'd2) return "R1 range fault";
      if (f == 3'd4) return "R9 access flag";
      if (f == 3'd3) return "R7/R8 translation fault";
      if (lv == 2) return "R5 block mapping";
      return "R6 page mapping";
   endfunction

   task automatic run_walk(input logic [63:0] va, input logic fetch, input bit poke);
      int start, cyc;
      bit got;
      logic [47:0] pa_c;
      logic [2:0] flt_c, lvl_c;
      string tg;
      ref_walk(va, fetch);
      tg = tag_for(exp_flt, exp_lvl);
      @(negedge clk);
      chk(req_ready == 1'b1, "R10 ready when idle", 64'(req_ready), 64'd1);
      start = rd_cnt;
      req_vaddr = va;
      req_is_fetch = fetch;
      req_valid = 1'b1;
      @(negedge clk);
      cyc = 0;
      got = 1'b0;
      pa_c = '0;
      flt_c = '0;
      lvl_c = '0;
      while (!got && cyc < 60) begin
         if (rsp_valid) begin
            pa_c = rsp_paddr;
            flt_c = rsp_fault;
            lvl_c = rsp_level;
            got = 1'b1;
         end
         if (cyc == 0 && poke) begin
            req_vaddr = 64'h0;
            req_is_fetch = 1'b0;
            req_valid = 1'b1;
            chk(req_ready == 1'b0, "R10 busy refuses", 64'(req_ready), 64'd0);
         end else begin
            req_valid = 1'b0;
         end
         if (cyc == 0 && (exp_flt == 3'd1 || exp_flt == 3'd2))
            chk(got, "R1 response in cycle after acceptance", 64'(got), 64'd1);
         if (!got) begin
            @(negedge clk);
            cyc++;
         end
      end
      chk(got, "R10 response arrives", 64'(got), 64'd1);
      chk(flt_c == exp_flt, tg, 64'(flt_c), 64'(exp_flt));
      chk(32'(lvl_c) == exp_lvl, {tg, " level"}, 64'(lvl_c), 64'(exp_lvl));
      chk(pa_c == exp_pa, {tg, " paddr"}, 64'(pa_c), 64'(exp_pa));
      chk(rd_cnt - start == exp_n, "R3 read count", 64'(rd_cnt - start), 64'(exp_n));
      for (int k = 0; k < exp_n && k < rd_cnt - start; k++)
         chk(rd_log[(start + k) % 8] == exp_ad[k], (k == 0) ? "R2 root read address" : "R4 level read address",
             64'(rd_log[(start + k) % 8]), 64'(exp_ad[k]));
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid == 1'b0, "R10 single-cycle response", 64'(rsp_valid), 64'd0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (rsp_valid || mem_req_valid)
            chk(1'b0, "R10 ignored request started work", 64'({rsp_valid, mem_req_valid}), 64'd0);
      end
      if (poke)
         chk(rd_cnt - start == exp_n, "R10 no read from refused request", 64'(rd_cnt - start), 64'(exp_n));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      int n;
      logic [63:0] va;
      logic [15:0] tops [4];
      int l1s [4];
      int u1s [3];
      tops[0] = 16'h0001; tops[1] = 16'h8000; tops[2] = 16'hFFFE; tops[3] = 16'h7FFF;
      l1s[0] = 0; l1s[1] = 1; l1s[2] = 2; l1s[3] = 511;
      u1s[0] = 0; u1s[1] = 511; u1s[2] = 3;
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R11 reset ready", 64'(req_ready), 64'd1);
      chk(mem_req_valid == 1'b0, "R11 reset read idle", 64'(mem_req_valid), 64'd0);
      chk(rsp_valid == 1'b0, "R11 reset no response", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0,
          "R11 after reset", 64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);
      n = 0;
      for (int t = 0; t < 4; t++) begin
         for (int f = 0; f < 2; f++) begin
            for (int p = 0; p < 2; p++) begin
               va = {tops[t], 48'h1234_5678_9ABC};
               run_walk(va, f[0], p[0]);
            end
         end
      end
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 6; b++) begin
            for (int c = 0; c < 3; c++) begin
               for (int d = 0; d < 8; d++) begin
                  va = (64'(l1s[a]) << 39) | (64'(b) << 30) | (64'(c) << 21) | (64'(d) << 12) |
                       64'((d * 421 + b * 8 + c) & 32'hFFF);
                  lat = 1 + (n % 3);
                  run_walk(va, n[0], (n % 4) == 1);
                  n++;
               end
            end
         end
      end
      for (int a = 0; a < 3; a++) begin
         for (int b = 0; b < 6; b++) begin
            for (int c = 0; c < 2; c++) begin
               for (int d = 0; d < 8; d++) begin
                  va = 64'hFFFF_0000_0000_0000 | (64'(u1s[a]) << 39) | (64'(b) << 30) |
                       (64'(c) << 21) | (64'(d) << 12) | 64'((d * 97 + 5) & 32'hFFF);
                  lat = 1 + (n % 3);
                  run_walk(va, 1'b0, (n % 5) == 2);
                  n++;
               end
            end
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule